// File: doc/BRIEF.md
# Self-Corrected Min-Sum Check Node Processor

This block performs the check-node update of one parity row for an iterative low-density parity-check decoder using the self-corrected min-sum rule. It works serially. The host announces a row with its degree, which may be up to 24 connections. It then streams one variable-to-check message per cycle. Each message is an 8-bit two's complement LLR, and it arrives together with the sign bit that the same edge carried in the previous iteration. A message whose sign has flipped since that iteration is judged unreliable. It is erased: it is replaced by a positive zero before the update. On the first iteration of a codeblock there is no earlier sign, so nothing is erased.

While the messages arrive, the block tracks the smallest magnitude, the second smallest magnitude, the position of the smallest, the parity of all signs and the number of erasures. Once the last message of the row has been accepted, it plays back one check-to-variable message per edge, in input order. On the final output it also reports the erasure count of the row, which iteration control uses.

The controller is a three-state machine. IDLE waits for `row_start`. The transition IDLE→COLLECT latches the degree and the first-iteration flag and clears the accumulators. COLLECT takes one message on each cycle that has `in_valid`. The transition COLLECT→EMIT fires when the last edge is accepted. EMIT drives one output per cycle. The transition EMIT→IDLE fires after the output for the last edge.

Top module: `scms_check_node`

## Requirements
- R1: After reset, `out_valid` and `out_last` are low and stay low until a row has been fully collected.
- R2: When `first_iter` was low at row start, an input is erased if its sign bit (bit 7, 1 = negative = bit value 1) differs from `in_prev_sign`. An erased input counts as magnitude 0 with a positive sign.
- R3: When `first_iter` was high at row start, no input is erased, whatever `in_prev_sign` holds, and the reported erasure count is 0.
- R4: The output magnitude for edge j is the minimum effective magnitude over all other edges of the row. An input of -128 has magnitude 127, so an output is never -128.
- R5: The output sign for edge j is the XOR of the effective signs of all other edges. A negative result is emitted as the two's complement negation of the magnitude.
- R6: If a row holds one erased input, every other edge receives 0 and the erased edge receives the minimum over the others. If a row holds two or more erased inputs, every output is 0.
- R7: Outputs appear on exactly `row_deg` consecutive cycles, in input order. The first one is in the cycle after the clock edge that accepts the last input. `out_last` marks the final output, and `out_valid` is low in the next cycle.
- R8: During the output phase, `erase_cnt` holds, unchanged, the number of erased inputs of the row. Its value at `out_last` is the row's count.
- R9: Any degree from 2 to 24 is handled, and rows can follow one another directly.
- R10: `in_valid` has no effect in IDLE or EMIT. Gaps in `in_valid` during COLLECT only delay the row and do not change its results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_start | input | 1 | Opens a row; taken in IDLE only |
| row_deg | input | 5 | Number of edges of the row (2..24), sampled with `row_start` |
| first_iter | input | 1 | First iteration of a codeblock, sampled with `row_start` |
| in_valid | input | 1 | An input message is present |
| in_llr | input | 8 | Variable-to-check LLR, two's complement |
| in_prev_sign | input | 1 | Sign bit this edge had in the previous iteration |
| out_valid | output | 1 | A check-to-variable message is present |
| out_llr | output | 8 | Check-to-variable LLR, two's complement |
| out_last | output | 1 | Final output of the row |
| erase_cnt | output | 5 | Erased inputs in the current row |

## Verification
No output appears until the edge that accepts the last input of a row. The output for edge k then follows k cycles later, and `erase_cnt` is valid alongside `out_last`. The bench drives inputs one time unit after a rising edge and samples on the falling edge. It keeps its expected values in a per-row behavioural model of minima over the other edges and sign parities. On every cycle of a row it compares `out_valid`: it must be low during collection and on the cycle after the burst, and high for exactly the degree count in between, with the value and the last flag compared on each output cycle.

// File: rtl/scms_pkg.sv
package scms_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_EMIT    = 2'd2
    } cn_state_e;
endpackage

// File: rtl/scms_input_clean.sv
// Erasure decision and saturated magnitude of one incoming message.
module scms_input_clean #(
    parameter int LLR_W = 8
) (
    input  logic [LLR_W-1:0] llr,
    input  logic             prev_sign,
    input  logic             first_pass,
    output logic [LLR_W-2:0] mag,
    output logic             sgn,
    output logic             erased
);
    localparam logic [LLR_W-1:0] MOST_NEG = {1'b1, {(LLR_W-1){1'b0}}};

    logic [LLR_W-1:0] neg_v;

    always_comb begin
        erased = !first_pass && (llr[LLR_W-1] != prev_sign);
        neg_v  = -llr;
        if (erased) begin
            mag = '0;
            sgn = 1'b0;
        end else if (llr == MOST_NEG) begin
            mag = '1;
            sgn = 1'b1;
        end else if (llr[LLR_W-1]) begin
            mag = neg_v[LLR_W-2:0];
            sgn = 1'b1;
        end else begin
            mag = llr[LLR_W-2:0];
            sgn = 1'b0;
        end
    end
endmodule

// File: rtl/scms_min_track.sv
// First-pass accumulators: two minima, their position, sign parity, erasures.
module scms_min_track #(
    parameter int MAG_W   = 7,
    parameter int MAX_DEG = 24,
    parameter int IDX_W   = 5,
    parameter int CNT_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               take,
    input  logic [IDX_W-1:0]   edge_idx,
    input  logic [MAG_W-1:0]   mag,
    input  logic               sgn,
    input  logic               erased,
    output logic [MAG_W-1:0]   min1,
    output logic [MAG_W-1:0]   min2,
    output logic [IDX_W-1:0]   min1_idx,
    output logic               sign_acc,
    output logic [MAX_DEG-1:0] sign_vec,
    output logic [CNT_W-1:0]   erase_cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            min1      <= '1;
            min2      <= '1;
            min1_idx  <= '0;
            sign_acc  <= 1'b0;
            sign_vec  <= '0;
            erase_cnt <= '0;
        end else if (clear) begin
            min1      <= '1;
            min2      <= '1;
            min1_idx  <= '0;
            sign_acc  <= 1'b0;
            sign_vec  <= '0;
            erase_cnt <= '0;
        end else if (take) begin
            sign_vec[edge_idx] <= sgn;
            sign_acc           <= sign_acc ^ sgn;
            if (erased) begin
                erase_cnt <= erase_cnt + 1'b1;
            end
            if (mag < min1) begin
                min2     <= min1;
                min1     <= mag;
                min1_idx <= edge_idx;
            end else if (mag < min2) begin
                min2 <= mag;
            end
        end
    end
endmodule

// File: rtl/scms_out_gen.sv
// Second-pass output: exclude own contribution from magnitude and sign.
module scms_out_gen #(
    parameter int LLR_W   = 8,
    parameter int MAX_DEG = 24,
    parameter int IDX_W   = 5
) (
    input  logic [IDX_W-1:0]   edge_idx,
    input  logic [LLR_W-2:0]   min1,
    input  logic [LLR_W-2:0]   min2,
    input  logic [IDX_W-1:0]   min1_idx,
    input  logic               sign_acc,
    input  logic [MAX_DEG-1:0] sign_vec,
    output logic [LLR_W-1:0]   llr
);
    logic [LLR_W-2:0] mag_sel;
    logic [LLR_W-1:0] ext;
    logic             s;

    always_comb begin
        mag_sel = (edge_idx == min1_idx) ? min2 : min1;
        s       = sign_acc ^ sign_vec[edge_idx];
        ext     = {1'b0, mag_sel};
        llr     = s ? -ext : ext;
    end
endmodule

// File: rtl/scms_check_node.sv
module scms_check_node #(
    parameter int LLR_W   = 8,
    parameter int MAX_DEG = 24
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         row_start,
    input  logic [$clog2(MAX_DEG+1)-1:0] row_deg,
    input  logic                         first_iter,
    input  logic                         in_valid,
    input  logic [LLR_W-1:0]             in_llr,
    input  logic                         in_prev_sign,
    output logic                         out_valid,
    output logic [LLR_W-1:0]             out_llr,
    output logic                         out_last,
    output logic [$clog2(MAX_DEG+1)-1:0] erase_cnt
);
    import scms_pkg::*;

    localparam int MAG_W = LLR_W - 1;
    localparam int IDX_W = $clog2(MAX_DEG);
    localparam int CNT_W = $clog2(MAX_DEG + 1);

    cn_state_e        state_q, state_d;
    logic [CNT_W-1:0] deg_q;
    logic             first_q;
    logic [IDX_W-1:0] edge_q;
    logic [IDX_W-1:0] last_edge;
    logic             at_last;
    logic             clear, take;

    logic [MAG_W-1:0]   c_mag;
    logic               c_sgn, c_erased;
    logic [MAG_W-1:0]   min1, min2;
    logic [IDX_W-1:0]   min1_idx;
    logic               sign_acc;
    logic [MAX_DEG-1:0] sign_vec;
    logic [LLR_W-1:0]   gen_llr;

    assign last_edge = IDX_W'(deg_q - 1'b1);
    assign at_last   = (edge_q == last_edge);
    assign clear     = (state_q == ST_IDLE) && row_start;
    assign take      = (state_q == ST_COLLECT) && in_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (row_start)           state_d = ST_COLLECT;
            ST_COLLECT: if (in_valid && at_last) state_d = ST_EMIT;
            ST_EMIT:    if (at_last)             state_d = ST_IDLE;
            default:                             state_d = ST_IDLE;
        endcase
    end

    // row context and edge counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            deg_q   <= '0;
            first_q <= 1'b0;
            edge_q  <= '0;
        end else begin
            if (clear) begin
                deg_q   <= row_deg;
                first_q <= first_iter;
                edge_q  <= '0;
            end else if (take || state_q == ST_EMIT) begin
                edge_q <= at_last ? '0 : edge_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        out_valid = (state_q == ST_EMIT);
        out_last  = out_valid && at_last;
        out_llr   = out_valid ? gen_llr : '0;
    end

    scms_input_clean #(.LLR_W(LLR_W)) u_clean (
        .llr        (in_llr),
        .prev_sign  (in_prev_sign),
        .first_pass (first_q),
        .mag        (c_mag),
        .sgn        (c_sgn),
        .erased     (c_erased)
    );

    scms_min_track #(
        .MAG_W   (MAG_W),
        .MAX_DEG (MAX_DEG),
        .IDX_W   (IDX_W),
        .CNT_W   (CNT_W)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .take      (take),
        .edge_idx  (edge_q),
        .mag       (c_mag),
        .sgn       (c_sgn),
        .erased    (c_erased),
        .min1      (min1),
        .min2      (min2),
        .min1_idx  (min1_idx),
        .sign_acc  (sign_acc),
        .sign_vec  (sign_vec),
        .erase_cnt (erase_cnt)
    );

    scms_out_gen #(
        .LLR_W   (LLR_W),
        .MAX_DEG (MAX_DEG),
        .IDX_W   (IDX_W)
    ) u_out (
        .edge_idx (edge_q),
        .min1     (min1),
        .min2     (min2),
        .min1_idx (min1_idx),
        .sign_acc (sign_acc),
        .sign_vec (sign_vec),
        .llr      (gen_llr)
    );
endmodule

// File: rtl/scms_check_node_chk.sv
module scms_check_node_chk #(
    parameter int LLR_W   = 8,
    parameter int MAX_DEG = 24
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         out_valid,
    input logic [LLR_W-1:0]             out_llr,
    input logic                         out_last,
    input logic [$clog2(MAX_DEG+1)-1:0] erase_cnt
);
    localparam logic [LLR_W-1:0] MOST_NEG = {1'b1, {(LLR_W-1){1'b0}}};

    assert_last_in_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    assert_burst_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> !out_valid);

    assert_no_most_neg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_llr != MOST_NEG));

    assert_zero_after_erasures_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && erase_cnt >= 2) |-> (out_llr == '0));

    assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (erase_cnt <= MAX_DEG));

    assert_count_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> $stable(erase_cnt));
endmodule

bind scms_check_node scms_check_node_chk #(
    .LLR_W   (LLR_W),
    .MAX_DEG (MAX_DEG)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_llr   (out_llr),
    .out_last  (out_last),
    .erase_cnt (erase_cnt)
);

// File: tb/test_scms_check_node.sv
module test_scms_check_node;
    localparam int LW = 8;
    localparam int MD = 24;
    localparam int CW = $clog2(MD + 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          row_start;
    logic [CW-1:0] row_deg;
    logic          first_iter;
    logic          in_valid;
    logic [LW-1:0] in_llr;
    logic          in_prev_sign;
    logic          out_valid;
    logic [LW-1:0] out_llr;
    logic          out_last;
    logic [CW-1:0] erase_cnt;

    int total = 0;
    int bad   = 0;
    int t_llr[MD];
    bit t_prev[MD];

    always #5 clk = ~clk;

    scms_check_node i_scms_check_node (
        .clk          (clk),
        .rst_n        (rst_n),
        .row_start    (row_start),
        .row_deg      (row_deg),
        .first_iter   (first_iter),
        .in_valid     (in_valid),
        .in_llr       (in_llr),
        .in_prev_sign (in_prev_sign),
        .out_valid    (out_valid),
        .out_llr      (out_llr),
        .out_last     (out_last),
        .erase_cnt    (erase_cnt)
    );

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference: effective value per edge, then min/xor over the other edges.
    task automatic run_row(int deg, bit first, bit gap, bit noise, string req);
        int em[MD];
        bit es[MD];
        int exp_out[MD];
        int ecount = 0;
        for (int i = 0; i < deg; i++) begin
            bit neg = (t_llr[i] < 0);
            bit er  = !first && (neg != t_prev[i]);
            if (er) begin
                em[i] = 0; es[i] = 0; ecount++;
            end else begin
                em[i] = (t_llr[i] == -128) ? 127 : (neg ? -t_llr[i] : t_llr[i]);
                es[i] = neg;
            end
        end
        for (int j = 0; j < deg; j++) begin
            int mn = 127;
            bit sx = 0;
            for (int i = 0; i < deg; i++) begin
                if (i != j) begin
                    if (em[i] < mn) mn = em[i];
                    sx ^= es[i];
                end
            end
            exp_out[j] = sx ? -mn : mn;
        end
        @(posedge clk); #1;
        row_start = 1'b1; row_deg = CW'(deg); first_iter = first; in_valid = 1'b0;
        @(posedge clk); #1;
        row_start = 1'b0;
        for (int k = 0; k < deg; k++) begin
            in_valid = 1'b1; in_llr = LW'(t_llr[k]); in_prev_sign = t_prev[k];
            @(negedge clk);
            check({req, " R7 quiet while collecting"}, int'(out_valid), 0);
            @(posedge clk); #1;
            in_valid = 1'b0;
            if (gap && k < deg - 1) begin
                in_llr = 8'h81;
                @(negedge clk);
                check({req, " R10 gap"}, int'(out_valid), 0);
                @(posedge clk); #1;
            end
        end
        for (int j = 0; j < deg; j++) begin
            if (noise) begin
                in_valid = 1'b1; in_llr = LW'($urandom_range(0, 255)); in_prev_sign = 1'b1;
            end
            @(negedge clk);
            check({req, " R7 out_valid"}, int'(out_valid), 1);
            check({req, " R4/R5 out_llr"}, int'($signed(out_llr)), exp_out[j]);
            check({req, " R7 out_last"}, int'(out_last), (j == deg - 1) ? 1 : 0);
            if (j == deg - 1) check({req, " R8 erase_cnt"}, int'(erase_cnt), ecount);
            @(posedge clk); #1;
        end
        in_valid = 1'b0;
        @(negedge clk);
        check({req, " R7 burst ended"}, int'(out_valid), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; row_start = 1'b0; row_deg = '0; first_iter = 1'b0;
        in_valid = 1'b0; in_llr = '0; in_prev_sign = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 out_valid in reset", int'(out_valid), 0);
        check("R1 out_last in reset", int'(out_last), 0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after reset", int'(out_valid), 0);

        // R10: valid pulses while idle must not start anything
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1 in_valid = 1'b1; in_llr = 8'h05;
            @(negedge clk);
            check("R10 idle input ignored", int'(out_valid), 0);
        end
        @(posedge clk); #1 in_valid = 1'b0;

        // R3/R4/R5: first iteration, mixed signs
        t_llr[0] = 10; t_llr[1] = -3; t_llr[2] = 7; t_llr[3] = -20;
        for (int i = 0; i < 4; i++) t_prev[i] = 1'b0;
        run_row(4, 1'b1, 1'b0, 1'b0, "R3 first iter mixed");

        // R4/R5: later iteration, no sign flips
        t_llr[0] = -40; t_llr[1] = 12; t_llr[2] = -9; t_llr[3] = 33; t_llr[4] = 60;
        t_prev[0] = 1; t_prev[1] = 0; t_prev[2] = 1; t_prev[3] = 0; t_prev[4] = 0;
        run_row(5, 1'b0, 1'b0, 1'b0, "R4 R5 no flips");

        // R2/R6: one flip
        t_llr[0] = 25; t_llr[1] = -14; t_llr[2] = 31; t_llr[3] = -8; t_llr[4] = 19;
        t_prev[0] = 0; t_prev[1] = 1; t_prev[2] = 1; t_prev[3] = 1; t_prev[4] = 0;
        run_row(5, 1'b0, 1'b0, 1'b0, "R2 R6 one erased");

        // R6/R8: two flips
        t_llr[0] = -50; t_llr[1] = 44; t_llr[2] = -6; t_llr[3] = 70;
        t_prev[0] = 0; t_prev[1] = 1; t_prev[2] = 1; t_prev[3] = 0;
        run_row(4, 1'b0, 1'b0, 1'b0, "R6 R8 two erased");

        // R3: same stimulus in first iteration: no erasure
        run_row(4, 1'b1, 1'b0, 1'b0, "R3 flips ignored");

        // R4: saturation of -128 and tied minima
        t_llr[0] = -128; t_llr[1] = 5; t_llr[2] = -5; t_llr[3] = -128;
        t_prev[0] = 1; t_prev[1] = 0; t_prev[2] = 1; t_prev[3] = 1;
        run_row(4, 1'b0, 1'b0, 1'b0, "R4 saturation ties");

        // R9: smallest degree, with noise during emission (R10)
        t_llr[0] = -77; t_llr[1] = 90;
        t_prev[0] = 1; t_prev[1] = 0;
        run_row(2, 1'b0, 1'b0, 1'b1, "R9 R10 degree 2 noisy emit");

        // R9/R10: full degree with gaps, then random rows back to back
        for (int i = 0; i < MD; i++) begin
            t_llr[i] = $urandom_range(0, 255) - 128;
            t_prev[i] = (t_llr[i] < 0);
        end
        run_row(MD, 1'b0, 1'b1, 1'b0, "R9 R10 degree 24 gaps");

        for (int r = 0; r < 20; r++) begin
            int d = $urandom_range(2, MD);
            for (int i = 0; i < d; i++) begin
                t_llr[i] = $urandom_range(0, 255) - 128;
                t_prev[i] = ($urandom_range(0, 5) == 0) ? !(t_llr[i] < 0) : (t_llr[i] < 0);
            end
            run_row(d, (r % 5) == 0, 1'b0, (r % 3) == 0, "R2 R4 R5 R9 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule